// File: doc/BRIEF.md
# Processor Bus Command Strobe Generator

This block turns the three-bit encoded bus status of a processor into the separate command strobes that memory and peripheral devices need. The strobes are interrupt acknowledge, I/O read, I/O write, memory read and memory write. Both write types also have an early (advanced) write strobe. The processor signals a bus cycle by moving its status away from the passive code. The block latches the code it sees at that point and holds the matching strobe for the whole cycle. It drops the strobe once the status goes back to passive.

Two more flags report how the cycle is classified. One marks opcode-fetch reads so that they can be told apart from data reads. The other marks halt cycles, which drive no command. A single enable input blanks every output immediately, for use when another agent owns the bus. All timing is counted in rising edges of one clock. The delay of the normal write strobe behind its advanced strobe is a parameter, with a default of one clock.

Top module: `bus_cmd_decoder`

## Requirements
- R1: While reset is high, and on the first clock after it falls with status at 111, every output is low.
- R2: The status code is read as {S2,S1,S0} = status[2:0]. Code 000 drives the interrupt acknowledge strobe. Code 001 drives I/O read and code 010 drives the I/O writes. Codes 100 and 101 drive memory read, and code 110 drives the memory writes.
- R3: A cycle starts on the rising edge at which the status is sampled as not 111 and the previous sample was 111. The read and advanced-write strobes rise on the next edge.
- R4: The code is latched when the cycle starts. Any other non-passive code that appears before the status returns to 111 has no effect on the outputs.
- R5: Each normal write strobe rises one clock after its advanced-write strobe. A cycle with only one non-passive status sample never raises the normal write.
- R6: Every strobe and flag falls on the edge after the edge that first samples status 111. A new cycle may begin on the very next sample.
- R7: The fetch flag is high with memory read for code 100. It stays low for code 101.
- R8: Code 011 raises the halt flag and raises none of the command strobes.
- R9: When enable is low, all outputs are low in the same cycle. When enable goes high again during a cycle, the cycle's outputs reappear at once.
- R10: At most one of interrupt acknowledge, I/O read, advanced I/O write, memory read and advanced memory write is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Output enable; low blanks every output |
| status | input | 3 | Encoded processor status {S2,S1,S0}; 111 is passive |
| cmd_inta | output | 1 | Interrupt acknowledge strobe |
| cmd_io_rd | output | 1 | I/O read strobe |
| cmd_io_wr | output | 1 | I/O write strobe (normal timing) |
| cmd_io_wr_adv | output | 1 | I/O write strobe (advanced timing) |
| cmd_mem_rd | output | 1 | Memory read strobe |
| cmd_mem_wr | output | 1 | Memory write strobe (normal timing) |
| cmd_mem_wr_adv | output | 1 | Memory write strobe (advanced timing) |
| cyc_fetch | output | 1 | Current cycle is an opcode fetch |
| cyc_halt | output | 1 | Current cycle is a halt |

## Verification
A wrongly latched cycle code appears at the ports on the edge after the cycle starts. It shows either as the wrong strobe or as a strobe that follows a mid-cycle status change. An activity flag that fails to clear shows as a strobe that stays high one edge too long after the passive code, or that fails to rise again for a back-to-back cycle. A fault in the write delay stage shows one edge later, as the normal write rising together with its advanced strobe, or not rising at all. The expected outputs are predicted for every clock of every cycle, so each of these faults is caught within two edges of its cause.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int STATUS_W = 3;

    typedef enum logic [STATUS_W-1:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MEMRD = 3'b101,
        ST_MEMWR = 3'b110,
        ST_IDLE  = 3'b111
    } bus_status_e;

    // Command set for one cycle; the write bits carry advanced timing.
    typedef struct packed {
        logic intack;
        logic io_rd;
        logic io_wr;
        logic mem_rd;
        logic mem_wr;
        logic fetch;
        logic halt;
    } cmd_t;

    localparam cmd_t CMD_NONE = '0;

    function automatic logic is_idle(input logic [STATUS_W-1:0] s);
        return s == ST_IDLE;
    endfunction

    function automatic cmd_t decode_status(input bus_status_e s);
        cmd_t c;
        c = CMD_NONE;
        unique case (s)
            ST_INTA:  c.intack = 1'b1;
            ST_IORD:  c.io_rd  = 1'b1;
            ST_IOWR:  c.io_wr  = 1'b1;
            ST_HALT:  c.halt   = 1'b1;
            ST_FETCH: begin
                c.mem_rd = 1'b1;
                c.fetch  = 1'b1;
            end
            ST_MEMRD: c.mem_rd = 1'b1;
            ST_MEMWR: c.mem_wr = 1'b1;
            default:  c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsd_cycle_track.sv
module bsd_cycle_track
    import bsd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STATUS_W-1:0] status_i,
    output logic                active_o,
    output bus_status_e         code_o
);

    logic [STATUS_W-1:0] prev_q;
    logic                start;

    assign start = is_idle(prev_q) && !is_idle(status_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= ST_IDLE;
            active_o <= 1'b0;
            code_o   <= ST_IDLE;
        end else begin
            prev_q <= status_i;
            if (is_idle(status_i)) begin
                active_o <= 1'b0;
            end else if (start) begin
                active_o <= 1'b1;
                code_o   <= bus_status_e'(status_i);
            end
        end
    end

    // R3: leaving passive opens a cycle carrying the new code
    assert_cycle_open_R3: assert property (@(posedge clk) disable iff (rst)
        (is_idle(prev_q) && !is_idle(status_i)) |=> (active_o && code_o == $past(status_i)));

    // R4: the latched code stays fixed while the status is non-passive
    assert_code_held_R4: assert property (@(posedge clk) disable iff (rst)
        (active_o && !is_idle(status_i)) |=> (active_o && $stable(code_o)));

    // R6: a passive sample closes the cycle
    assert_cycle_close_R6: assert property (@(posedge clk) disable iff (rst)
        is_idle(status_i) |=> !active_o);

endmodule

// File: rtl/bsd_strobe_gen.sv
module bsd_strobe_gen
    import bsd_pkg::*;
#(
    parameter int LATE_WR_DLY = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        active_i,
    input  bus_status_e code_i,
    output cmd_t        cmd_o,
    output logic        io_wr_late_o,
    output logic        mem_wr_late_o
);

    localparam int NSTAGE = LATE_WR_DLY + 1;

    // stage[g] bit1 = I/O write, bit0 = memory write
    logic [1:0] stage [NSTAGE];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o <= CMD_NONE;
        end else if (active_i) begin
            cmd_o <= decode_status(code_i);
        end else begin
            cmd_o <= CMD_NONE;
        end
    end

    assign stage[0] = {cmd_o.io_wr, cmd_o.mem_wr};

    generate
        for (genvar g = 0; g < LATE_WR_DLY; g++) begin : g_late
            always_ff @(posedge clk) begin
                if (rst || !active_i) begin
                    stage[g+1] <= 2'b00;
                end else begin
                    stage[g+1] <= stage[g];
                end
            end
        end
    endgenerate

    assign io_wr_late_o  = stage[LATE_WR_DLY][1];
    assign mem_wr_late_o = stage[LATE_WR_DLY][0];

    // R10: only one primary strobe at a time
    assert_one_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_o.intack, cmd_o.io_rd, cmd_o.io_wr, cmd_o.mem_rd, cmd_o.mem_wr}));

    // R6: no strobe survives past the edge after the cycle closes
    assert_idle_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (cmd_o == CMD_NONE && !io_wr_late_o && !mem_wr_late_o));

    // R8: halt carries no command
    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_o.halt |-> !(cmd_o.intack || cmd_o.io_rd || cmd_o.io_wr || cmd_o.mem_rd || cmd_o.mem_wr));

    // R7: fetch is a flavour of memory read
    assert_fetch_is_read_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_o.fetch |-> cmd_o.mem_rd);

endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
    import bsd_pkg::*;
#(
    parameter int LATE_WR_DLY = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [STATUS_W-1:0] status,
    output logic                cmd_inta,
    output logic                cmd_io_rd,
    output logic                cmd_io_wr,
    output logic                cmd_io_wr_adv,
    output logic                cmd_mem_rd,
    output logic                cmd_mem_wr,
    output logic                cmd_mem_wr_adv,
    output logic                cyc_fetch,
    output logic                cyc_halt
);

    logic        active;
    bus_status_e code;
    cmd_t        cmd;
    logic        io_late;
    logic        mem_late;

    bsd_cycle_track u_track (
        .clk      (clk),
        .rst      (rst),
        .status_i (status),
        .active_o (active),
        .code_o   (code)
    );

    bsd_strobe_gen #(
        .LATE_WR_DLY (LATE_WR_DLY)
    ) u_strobe (
        .clk           (clk),
        .rst           (rst),
        .active_i      (active),
        .code_i        (code),
        .cmd_o         (cmd),
        .io_wr_late_o  (io_late),
        .mem_wr_late_o (mem_late)
    );

    always_comb begin
        cmd_inta       = en && cmd.intack;
        cmd_io_rd      = en && cmd.io_rd;
        cmd_io_wr_adv  = en && cmd.io_wr;
        cmd_io_wr      = en && io_late;
        cmd_mem_rd     = en && cmd.mem_rd;
        cmd_mem_wr_adv = en && cmd.mem_wr;
        cmd_mem_wr     = en && mem_late;
        cyc_fetch      = en && cmd.fetch;
        cyc_halt       = en && cmd.halt;
    end

    // R5: a normal write is always covered by its advanced strobe
    assert_io_wr_order_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_io_wr |-> cmd_io_wr_adv);

    assert_mem_wr_order_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_mem_wr |-> cmd_mem_wr_adv);

    // R5: normal write rises only after an edge on which its advanced strobe was high
    assert_mem_wr_late_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_late) |-> $past(cmd.mem_wr));

    // R9: a low enable keeps every output low
    assert_enable_blank_R9: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(cmd_inta || cmd_io_rd || cmd_io_wr || cmd_io_wr_adv || cmd_mem_rd ||
                  cmd_mem_wr || cmd_mem_wr_adv || cyc_fetch || cyc_halt));

endmodule

// File: tb/test_bus_cmd_decoder.sv
module test_bus_cmd_decoder;

    typedef struct {
        logic [8:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic [2:0] status = 3'b111;
    logic       cmd_inta, cmd_io_rd, cmd_io_wr, cmd_io_wr_adv, cmd_mem_rd;
    logic       cmd_mem_wr, cmd_mem_wr_adv, cyc_fetch, cyc_halt;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb [$];

    always #10 clk = ~clk;

    bus_cmd_decoder i_bus_cmd_decoder (
        .clk(clk), .rst(rst), .en(en), .status(status),
        .cmd_inta(cmd_inta), .cmd_io_rd(cmd_io_rd), .cmd_io_wr(cmd_io_wr),
        .cmd_io_wr_adv(cmd_io_wr_adv), .cmd_mem_rd(cmd_mem_rd), .cmd_mem_wr(cmd_mem_wr),
        .cmd_mem_wr_adv(cmd_mem_wr_adv), .cyc_fetch(cyc_fetch), .cyc_halt(cyc_halt)
    );

    // order: inta, io_rd, io_wr, io_wr_adv, mem_rd, mem_wr, mem_wr_adv, fetch, halt
    function automatic logic [8:0] outs();
        return {cmd_inta, cmd_io_rd, cmd_io_wr, cmd_io_wr_adv, cmd_mem_rd,
                cmd_mem_wr, cmd_mem_wr_adv, cyc_fetch, cyc_halt};
    endfunction

    // Expected outputs after edge i of a cycle whose first non-passive edge is i=0
    function automatic logic [8:0] expect_at(input logic [2:0] code, input int i, input int len);
        logic [8:0] v;
        bit         late;
        v = '0;
        late = (i >= 2);
        if (i >= 1 && i <= len) begin
            case (code)
                3'b000: v[8] = 1'b1;
                3'b001: v[7] = 1'b1;
                3'b010: begin v[5] = 1'b1; v[6] = late; end
                3'b011: v[0] = 1'b1;
                3'b100: begin v[4] = 1'b1; v[1] = 1'b1; end
                3'b101: v[4] = 1'b1;
                3'b110: begin v[2] = 1'b1; v[3] = late; end
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: outputs=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one cycle of code for len samples, then gap passive samples.
    task automatic run_txn(input logic [2:0] code, input int len, input int gap,
                           input logic [2:0] alt, input int alt_from,
                           input int en_lo, input int en_hi, input string tag);
        item_t it;
        for (int i = 0; i < len + gap; i++) begin
            @(negedge clk);
            if (i < len) status = (alt_from >= 0 && i >= alt_from) ? alt : code;
            else         status = 3'b111;
            en = !(i >= en_lo && i < en_hi);
            it.exp = en ? expect_at(code, i, len) : 9'b0;
            it.tag = tag;
            sb.push_back(it);
        end
    endtask

    // Monitor: compare a quarter period after each rising edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(outs(), it.exp, it.tag);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(outs(), 9'b0, "R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check(outs(), 9'b0, "R1 after reset");

        run_txn(3'b000, 3, 2, 3'b000, -1, -1, -1, "R2 R3 R6 intack");
        run_txn(3'b001, 2, 1, 3'b000, -1, -1, -1, "R2 R6 io read back-to-back");
        run_txn(3'b010, 4, 2, 3'b000, -1, -1, -1, "R2 R5 io write");
        run_txn(3'b011, 3, 1, 3'b000, -1, -1, -1, "R8 halt");
        run_txn(3'b100, 3, 1, 3'b000, -1, -1, -1, "R7 fetch");
        run_txn(3'b101, 2, 1, 3'b000, -1, -1, -1, "R7 R2 data read");
        run_txn(3'b110, 3, 3, 3'b000, -1, -1, -1, "R2 R5 mem write");
        run_txn(3'b001, 4, 1, 3'b110, 2, -1, -1, "R4 code change ignored");
        run_txn(3'b110, 5, 1, 3'b000, -1, 2, 4, "R9 enable low mid-cycle");
        run_txn(3'b010, 4, 2, 3'b000, -1, 0, 6, "R9 enable low whole cycle");
        run_txn(3'b110, 1, 2, 3'b000, -1, -1, -1, "R5 single-sample write");
        run_txn(3'b000, 2, 1, 3'b000, -1, -1, -1, "R10 R6 intack short");
        run_txn(3'b101, 2, 2, 3'b000, -1, -1, -1, "R10 R6 read after intack");

        repeat (4) @(negedge clk);
        check(outs(), 9'b0, "R6 idle at end");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule